// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Front End

This block is the host side of a scatter-gather DMA engine. Software builds a descriptor by writing 32-bit words into an eight-word window. The words collect in a staging buffer. A write to the control word that carries the go bit pushes the full descriptor into a descriptor FIFO. A downstream transfer engine pulls descriptors through a valid/ready port. When it finishes one, it reports a completion with an 8-bit error code and an early-termination flag. The block does not move any data itself.

The block holds one descriptor in flight at a time. It records the sequence numbers of the descriptor most recently dispatched and the descriptor most recently completed. It raises an interrupt according to each descriptor's own enable bits. A completion with an error, or one that ended early, can halt dispatch until software clears the flag. A software reset empties the queue. The block then stays in a resetting phase for a fixed number of cycles.

Top module: `dma_desc_frontend`

## Requirements
- R1: After reset, status (word address 0) reads 0x0000000A (descriptor queue empty at bit 1, response buffer empty at bit 3), and control (address 1), fill (address 2), `irq` and `desc_valid` are all 0.
- R2: Descriptor word i is written at word address 8+i, for i from 0 to 7. Word 3 carries the sequence number in bits 15:0, and word 7 is the control word. Writing word 7 with bit 31 set queues the staged words. The descriptor then appears on `desc_data` with word i at bits 32i+31:32i. The fill register reads back the queue depth in bits 15:0.
- R3: A write to word 7 with bit 31 clear queues nothing. The word is still kept in the staging buffer, which reads back at addresses 8 to 15.
- R4: A commit made while the queue holds DEPTH entries is dropped, and status bit 10 (overflow) is set. Status bit 2 shows a full queue. Writing 1 to status bit 10 clears it.
- R5: Only one descriptor is in flight at a time. `desc_valid` stays low from the pop until its completion, and fill bits 31:16 read 1 during that time.
- R6: Sequence register (address 3) bits 15:0 hold the sequence number of the last dispatched descriptor. Bits 31:16 hold the sequence number of the last completed descriptor.
- R7: A completion sets status bit 9 when the control word has bit 14 set, when the error ANDed with control bits 23:16 is nonzero, or when the completion ended early and bit 15 is set. `irq` equals status bit 9 ANDed with control-register bit 4. Writing 1 to status bit 9 clears it.
- R8: When control-register bit 2 is set, a completion with a nonzero error sets status bits 7 and 5 and halts dispatch. Both stay set until software writes 1 to status bit 7.
- R9: When control-register bit 3 is set, an early-terminated completion sets status bits 8 and 5 and halts dispatch. Both stay set until software writes 1 to status bit 8.
- R10: Control-register bit 0 (stop) or bit 5 (stop fetching) holds `desc_valid` low and sets status bit 5.
- R11: Writing control-register bit 1 empties the queue, drops the in-flight descriptor, and clears the control register and all status flags. Status bit 6 then reads 1 for RESET_CYCLES cycles. Commits made during that time are ignored.
- R12: Status bit 0 (busy) reads 1 while the queue holds a descriptor or one is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| desc_valid | output | 1 | A descriptor is offered downstream |
| desc_ready | input | 1 | The downstream engine accepts the descriptor |
| desc_data | output | 256 | Offered descriptor, eight words |
| cpl_valid | input | 1 | Completion report for the in-flight descriptor |
| cpl_error | input | 8 | Error code of the completion |
| cpl_early | input | 1 | The completion ended early |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=2 and RESET_CYCLES=5. With these values, three commits behind a stop fill the queue and reach the overflow drop. The resetting phase is also short enough to commit into it and then watch it end. The table-driven part runs six descriptors through the interrupt rule, covering complete-enable, masked and unmasked errors, and early termination with and without its enable.

// File: rtl/dma_desc_frontend.sv
module dma_desc_frontend #(
  parameter int DEPTH        = 4,
  parameter int RESET_CYCLES = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = AW + 1,
  localparam int RCW = $clog2(RESET_CYCLES + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [3:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         desc_valid,
  input  logic         desc_ready,
  output logic [255:0] desc_data,
  input  logic         cpl_valid,
  input  logic [7:0]   cpl_error,
  input  logic         cpl_early,
  output logic         irq
);

  logic [31:0]    stage [8];
  logic [255:0]   mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic [5:0]     ctl;
  logic           inflight, fl_cie, fl_eie;
  logic [7:0]     fl_emask;
  logic [15:0]    fl_seq, rd_seq, wr_seq;
  logic           irq_pend, st_err, st_early, ovf;
  logic [RCW-1:0] rst_cnt;

  wire resetting = rst_cnt != '0;
  wire ctl_wr    = reg_wr && reg_addr == 4'd1;
  wire sw_rst    = ctl_wr && reg_wdata[1];
  wire st_w1c    = reg_wr && reg_addr == 4'd0;
  wire commit    = reg_wr && reg_addr == 4'd15 && reg_wdata[31];
  wire full      = cnt == CW'(DEPTH);
  wire halt      = ctl[0] | ctl[5] | st_err | st_early;
  wire push      = commit && !full && !resetting;
  wire pop       = desc_valid && desc_ready;
  wire cpl       = cpl_valid && inflight && !resetting;
  wire raise     = cpl && (fl_cie || |(cpl_error & fl_emask) || (cpl_early && fl_eie));
  wire busy      = cnt != '0 || inflight;

  assign desc_valid = cnt != '0 && !inflight && !halt && !resetting;
  assign desc_data  = mem[rp];
  assign irq        = irq_pend & ctl[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int i = 0; i < 8; i++) stage[i] <= '0;
    else if (reg_wr && reg_addr[3])
      stage[reg_addr[2:0]] <= reg_wdata;

  always_ff @(posedge clk)
    if (push && !sw_rst)
      mem[wp] <= {reg_wdata, stage[6], stage[5], stage[4], stage[3],
                  stage[2], stage[1], stage[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ctl <= '0;
      inflight <= 1'b0; fl_cie <= 1'b0; fl_eie <= 1'b0; fl_emask <= '0;
      fl_seq <= '0; rd_seq <= '0; wr_seq <= '0;
      irq_pend <= 1'b0; st_err <= 1'b0; st_early <= 1'b0; ovf <= 1'b0;
      rst_cnt <= '0;
    end else if (sw_rst) begin
      wp <= '0; rp <= '0; cnt <= '0; ctl <= '0;
      inflight <= 1'b0; rd_seq <= '0; wr_seq <= '0;
      irq_pend <= 1'b0; st_err <= 1'b0; st_early <= 1'b0; ovf <= 1'b0;
      rst_cnt <= RCW'(RESET_CYCLES);
    end else begin
      if (resetting) rst_cnt <= rst_cnt - 1'b1;
      if (ctl_wr) ctl <= reg_wdata[5:0] & 6'b111101;
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) begin
        rp       <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        inflight <= 1'b1;
        fl_cie   <= desc_data[238];
        fl_eie   <= desc_data[239];
        fl_emask <= desc_data[247:240];
        fl_seq   <= desc_data[111:96];
        rd_seq   <= desc_data[111:96];
      end
      cnt <= cnt + CW'(push) - CW'(pop);
      if (cpl) begin
        inflight <= 1'b0;
        wr_seq   <= fl_seq;
      end
      irq_pend <= (irq_pend & !(st_w1c & reg_wdata[9])) | raise;
      st_err   <= (st_err & !(st_w1c & reg_wdata[7])) | (cpl && ctl[2] && cpl_error != '0);
      st_early <= (st_early & !(st_w1c & reg_wdata[8])) | (cpl && ctl[3] && cpl_early);
      ovf      <= (ovf & !(st_w1c & reg_wdata[10])) | (commit && full && !resetting);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0: reg_rdata = {21'b0, ovf, irq_pend, st_early, st_err, resetting, halt,
                         1'b0, 1'b1, full, cnt == '0, busy};
      4'd1: reg_rdata = {26'b0, ctl};
      4'd2: reg_rdata = {15'b0, inflight, 16'(cnt)};
      4'd3: reg_rdata = {wr_seq, rd_seq};
      default: if (reg_addr[3]) reg_rdata = stage[reg_addr[2:0]];
    endcase
  end

endmodule

// File: rtl/dma_desc_frontend_chk.sv
module dma_desc_frontend_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [CW-1:0] cnt,
  input logic          inflight,
  input logic          fl_cie,
  input logic          cpl_valid,
  input logic          resetting,
  input logic          sw_rst,
  input logic          commit,
  input logic          st_err,
  input logic          irq_pend,
  input logic          ovf
);

  a_r2_commit_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cnt != CW'(DEPTH) && !resetting && !sw_rst && !(desc_valid && desc_ready))
    |=> cnt == $past(cnt) + 1'b1);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cnt == CW'(DEPTH) && !resetting && !sw_rst) |=> (ovf && cnt <= CW'(DEPTH)));

  a_r5_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !desc_valid);

  a_r7_cpl_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && inflight && fl_cie && !resetting && !sw_rst) |=> irq_pend);

  a_r8_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> !desc_valid);

  a_r11_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> (cnt == '0 && !desc_valid && !inflight));

endmodule

bind dma_desc_frontend dma_desc_frontend_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .cnt(cnt), .inflight(inflight), .fl_cie(fl_cie), .cpl_valid(cpl_valid),
  .resetting(resetting), .sw_rst(sw_rst), .commit(commit), .st_err(st_err),
  .irq_pend(irq_pend), .ovf(ovf)
);

// File: tb/dma_desc_frontend_tb_top.sv
`timescale 1ns/1ps
module dma_desc_frontend_tb_top;

  logic         clk = 1'b0;
  logic         rst_n, reg_wr, desc_ready, cpl_valid, cpl_early;
  logic [3:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata, rv;
  logic [7:0]   cpl_error;
  logic         desc_valid, irq;
  logic [255:0] desc_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dma_desc_frontend #(.DEPTH(2), .RESET_CYCLES(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_data(desc_data), .cpl_valid(cpl_valid),
    .cpl_error(cpl_error), .cpl_early(cpl_early), .irq(irq)
  );

  // fields: ctl[57:26] seq[25:10] err[9:2] early[1] expected_irq[0]
  localparam logic [57:0] VEC [6] = '{
    {32'h8000_4000, 16'h0001, 8'h00, 1'b0, 1'b1},
    {32'h8000_0000, 16'h0002, 8'h00, 1'b0, 1'b0},
    {32'h8003_0000, 16'h0003, 8'h02, 1'b0, 1'b1},
    {32'h8003_0000, 16'h0004, 8'h04, 1'b0, 1'b0},
    {32'h8000_8000, 16'h0005, 8'h00, 1'b1, 1'b1},
    {32'h8000_0000, 16'h0006, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] word(input int k, input int i, input logic [15:0] seq);
    return (i == 3) ? {16'h0, seq} : 32'hA000_0000 | 32'(k << 8) | 32'(i);
  endfunction

  task automatic put_desc(input int k, input logic [31:0] ctlw, input logic [15:0] seq);
    for (int i = 0; i < 7; i++) wr(4'(8 + i), word(k, i, seq));
    wr(4'd15, ctlw);
  endtask

  task automatic pop();
    @(negedge clk); desc_ready = 1'b1;
    @(negedge clk); desc_ready = 1'b0;
  endtask

  task automatic complete(input logic [7:0] e, input logic early);
    @(negedge clk); cpl_valid = 1'b1; cpl_error = e; cpl_early = early;
    @(negedge clk); cpl_valid = 1'b0; cpl_error = '0; cpl_early = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    desc_ready = 1'b0; cpl_valid = 1'b0; cpl_error = '0; cpl_early = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'd0, rv); chk("R1 status", rv, 32'h0000_000A);
    rd(4'd1, rv); chk("R1 control", rv, 32'h0);
    rd(4'd2, rv); chk("R1 fill", rv, 32'h0);
    chk("R1 irq/valid", {30'b0, irq, desc_valid}, 32'h0);

    wr(4'd1, 32'h10);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] c; logic [15:0] s; logic [7:0] e; logic early, xi;
      {c, s, e, early, xi} = VEC[k];
      put_desc(k, c, s);
      rd(4'd2, rv); chk("R2 fill after commit", rv, 32'h1);
      chk("R2 desc_valid", 32'(desc_valid), 32'h1);
      for (int i = 0; i < 8; i++)
        chk("R2 desc word", desc_data[32*i +: 32], (i == 7) ? c : word(k, i, s));
      pop();
      rd(4'd2, rv); chk("R5 fill in flight", rv, 32'h0001_0000);
      chk("R5 no second offer", 32'(desc_valid), 32'h0);
      rd(4'd0, rv); chk("R12 busy in flight", rv & 32'h1, 32'h1);
      rd(4'd3, rv); chk("R6 read seq", rv & 32'hFFFF, 32'(s));
      complete(e, early);
      rd(4'd0, rv); chk("R7 pending bit", (rv >> 9) & 32'h1, 32'(xi));
      chk("R7 irq pin", 32'(irq), 32'(xi));
      rd(4'd3, rv); chk("R6 write seq", rv >> 16, 32'(s));
      wr(4'd0, 32'h200);
      chk("R7 irq cleared", 32'(irq), 32'h0);
    end

    wr(4'd15, 32'h0000_4000);
    rd(4'd2, rv); chk("R3 no commit without go", rv, 32'h0);
    rd(4'd15, rv); chk("R3 staged control", rv, 32'h0000_4000);

    wr(4'd1, 32'h1);
    for (int j = 0; j < 3; j++) put_desc(10 + j, 32'h8000_0000, 16'(16 + j));
    rd(4'd2, rv); chk("R4 fill capped", rv, 32'h2);
    rd(4'd0, rv); chk("R4 full+overflow status", rv, 32'h0000_042D);
    chk("R10 stop holds valid", 32'(desc_valid), 32'h0);
    wr(4'd0, 32'h400);
    rd(4'd0, rv); chk("R4 overflow cleared", rv, 32'h0000_002D);
    wr(4'd1, 32'h20);
    chk("R10 stop-fetch holds valid", 32'(desc_valid), 32'h0);
    rd(4'd0, rv); chk("R10 stopped bit", rv & 32'h20, 32'h20);
    wr(4'd1, 32'h0);
    chk("R10 resumes", 32'(desc_valid), 32'h1);

    wr(4'd1, 32'h4);
    pop();
    complete(8'h01, 1'b0);
    rd(4'd0, rv); chk("R8 stopped on error", rv, 32'h0000_00A9);
    chk("R8 halted", 32'(desc_valid), 32'h0);
    wr(4'd0, 32'h80);
    chk("R8 resumes after clear", 32'(desc_valid), 32'h1);

    wr(4'd1, 32'h8);
    pop();
    put_desc(20, 32'h8000_0000, 16'h0012);
    complete(8'h00, 1'b1);
    rd(4'd0, rv); chk("R9 stopped on early", rv, 32'h0000_0129);
    chk("R9 halted", 32'(desc_valid), 32'h0);
    wr(4'd0, 32'h100);
    chk("R9 resumes after clear", 32'(desc_valid), 32'h1);

    wr(4'd1, 32'h2);
    rd(4'd0, rv); chk("R11 resetting status", rv, 32'h0000_004A);
    chk("R11 nothing offered", 32'(desc_valid), 32'h0);
    wr(4'd15, 32'h8000_0000);
    rd(4'd2, rv); chk("R11 commit ignored", rv, 32'h0);
    repeat (6) @(negedge clk);
    rd(4'd0, rv); chk("R11 reset finished", rv, 32'h0000_000A);
    rd(4'd1, rv); chk("R11 control cleared", rv, 32'h0);
    put_desc(30, 32'h8000_0000, 16'h0030);
    rd(4'd2, rv); chk("R11 commits after reset", rv, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule